// File: doc/BRIEF.md
# Sign and Parity/Overflow Flag Unit

This block keeps the sign flag and the shared parity/overflow flag of an 8-bit accumulator processor. On each cycle where the flag write enable is high, it recomputes both flags from the current operation class. Its inputs are the operation class, the two operands, the ALU result, the post-operation byte counter and the interrupt-enable state. The two flags are held in registers. A combinational condition output reports whether one of four selectable jump conditions holds against the registered flags.

The parity/overflow flag has four possible sources, chosen by operation class:
- signed overflow, for arithmetic;
- even parity of the result, for logic and two-byte rotate/shift;
- a byte counter that is not zero, for block transfer and compare;
- the interrupt-enable state, for loads of the accumulator from the interrupt register.

One-byte accumulator rotates and reserved class codes leave both flags untouched. The ALU, the other flags and instruction decoding live elsewhere.

Top module: `spf_flag_unit`

## Requirements
- R1: While `rst_n` is low, `sign_flag` and `pv_flag` are both 0. The clear takes effect without waiting for a clock edge.
- R2: On a rising clock edge with `flag_we` low, both flags keep their previous values.
- R3: Class codes on `op_class` are: increment 0, decrement 1, add 2, subtract 3, logic 4, two-byte rotate/shift 5, one-byte rotate 6, block transfer/compare 7, load-from-interrupt-register 8. Codes 9 to 15 are reserved. For codes 0 to 5, 7 and 8 with `flag_we` high, `sign_flag` becomes bit 7 of `result` at the edge.
- R4: For logic (4) and two-byte rotate/shift (5), `pv_flag` becomes 1 when `result` has an even number of 1 bits (zero counts as even), else 0.
- R5: For add (2), `pv_flag` becomes 1 exactly when `op_a + op_b` overflows as a signed 8-bit sum. For subtract (3), it becomes 1 exactly when `op_a - op_b` overflows as a signed 8-bit difference.
- R6: For increment (0), `pv_flag` becomes 1 only when `op_a` is 0x7F. For decrement (1), it becomes 1 only when `op_a` is 0x80.
- R7: For block transfer/compare (7), `pv_flag` becomes 0 when `byte_count` is zero, else 1.
- R8: For load-from-interrupt-register (8), `pv_flag` becomes the value of `int_en`.
- R9: One-byte rotate (6) and reserved codes 9 to 15 leave both flags unchanged, even with `flag_we` high.
- R10: `cond_true` is combinational from the registered flags and `cond_sel`:
  - 0 (positive) is true when `sign_flag` is 0;
  - 1 (minus) is true when `sign_flag` is 1;
  - 2 (parity odd) is true when `pv_flag` is 0;
  - 3 (parity even) is true when `pv_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Flag write enable for this cycle |
| op_class | input | 4 | Operation class code |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| result | input | 8 | ALU result |
| byte_count | input | 16 | Byte counter after the operation |
| int_en | input | 1 | Interrupt-enable state |
| cond_sel | input | 2 | Condition code to evaluate |
| sign_flag | output | 1 | Registered sign flag |
| pv_flag | output | 1 | Registered parity/overflow flag |
| cond_true | output | 1 | Selected condition holds |

## Verification
Overflow is tried with several directed cases:
- add and subtract operand pairs on both sides of the 0x7F/0x80 boundary, which separates true signed overflow from a plain carry out;
- increment at 0x7F and 0x7E, and decrement at 0x80 and 0x81.

Parity is tried on 0x00, 0xFF and odd-weight bytes. A result with bit 7 set but even weight shows that the sign and parity/overflow sources stay separate.

Block operations run with the counter at zero, at one and with only the top bit set, which catches a test that looks at only part of the counter. One-byte rotates, reserved codes and disabled writes follow operations that set the flags, so an unwanted update is visible. All four condition codes are read after every step. Long constrained random runs mix every class with these directed cases.

// File: rtl/spf_pkg.sv
package spf_pkg;

  localparam int OP_W   = 4;
  localparam int COND_W = 2;

  typedef enum logic [OP_W-1:0] {
    OPC_INC   = 4'd0,
    OPC_DEC   = 4'd1,
    OPC_ADD   = 4'd2,
    OPC_SUB   = 4'd3,
    OPC_LOGIC = 4'd4,
    OPC_ROT2  = 4'd5,
    OPC_ROT1  = 4'd6,
    OPC_BLOCK = 4'd7,
    OPC_LDIRQ = 4'd8
  } op_class_e;

  typedef enum logic [COND_W-1:0] {
    CND_POS  = 2'd0,
    CND_MIN  = 2'd1,
    CND_ODD  = 2'd2,
    CND_EVEN = 2'd3
  } cond_e;

  typedef struct packed {
    logic sign;
    logic pv;
  } flags_t;

endpackage

// File: rtl/spf_overflow.sv
module spf_overflow
  import spf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_class,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              ovf
);

  localparam int LOW_W = DATA_W - 1;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {LOW_W{1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {LOW_W{1'b0}}};

  logic [DATA_W-1:0] b_eff;
  logic              c_in;
  logic [LOW_W:0]    low_sum;
  logic [DATA_W:0]   full_sum;
  logic              carry_into_msb;
  logic              carry_out_msb;
  logic              arith_ovf;

  // Subtraction is addition of the inverted operand with a carry in.
  always_comb begin
    if (op_class == OPC_SUB) begin
      b_eff = ~op_b;
      c_in  = 1'b1;
    end else begin
      b_eff = op_b;
      c_in  = 1'b0;
    end
  end

  always_comb begin
    low_sum  = {1'b0, op_a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, c_in};
    full_sum = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_in};
    carry_into_msb = low_sum[LOW_W];
    carry_out_msb  = full_sum[DATA_W];
    arith_ovf      = carry_into_msb ^ carry_out_msb;
  end

  always_comb begin
    unique case (op_class)
      OPC_INC:          ovf = (op_a == MAX_POS);
      OPC_DEC:          ovf = (op_a == MIN_NEG);
      OPC_ADD, OPC_SUB: ovf = arith_ovf;
      default:          ovf = 1'b0;
    endcase
  end

endmodule

// File: rtl/spf_parity.sv
module spf_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic              even
);

  logic [DATA_W-1:0] chain;

  assign chain[0] = data[0];

  generate
    for (genvar gi = 1; gi < DATA_W; gi++) begin : g_xor
      assign chain[gi] = chain[gi-1] ^ data[gi];
    end
  endgenerate

  assign even = ~chain[DATA_W-1];

endmodule

// File: rtl/spf_pv_select.sv
module spf_pv_select
  import spf_pkg::*;
(
  input  logic [OP_W-1:0] op_class,
  input  logic            ovf,
  input  logic            par_even,
  input  logic            cnt_nz,
  input  logic            int_en,
  output logic            upd,
  output logic            pv_src
);

  always_comb begin
    upd    = 1'b1;
    pv_src = 1'b0;
    unique case (op_class)
      OPC_INC, OPC_DEC,
      OPC_ADD, OPC_SUB:    pv_src = ovf;
      OPC_LOGIC, OPC_ROT2: pv_src = par_even;
      OPC_BLOCK:           pv_src = cnt_nz;
      OPC_LDIRQ:           pv_src = int_en;
      default:             upd    = 1'b0;
    endcase
  end

endmodule

// File: rtl/spf_cond_eval.sv
module spf_cond_eval
  import spf_pkg::*;
(
  input  flags_t            flags,
  input  logic [COND_W-1:0] cond_sel,
  output logic              cond_true
);

  always_comb begin
    unique case (cond_e'(cond_sel))
      CND_POS:  cond_true = ~flags.sign;
      CND_MIN:  cond_true =  flags.sign;
      CND_ODD:  cond_true = ~flags.pv;
      CND_EVEN: cond_true =  flags.pv;
      default:  cond_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/spf_flag_unit.sv
module spf_flag_unit
  import spf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_we,
  input  logic [3:0]        op_class,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] result,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              int_en,
  input  logic [1:0]        cond_sel,
  output logic              sign_flag,
  output logic              pv_flag,
  output logic              cond_true
);

  localparam int MSB = DATA_W - 1;

  logic   ovf;
  logic   par_even;
  logic   cnt_nz;
  logic   upd;
  logic   pv_src;
  logic   load_en;
  flags_t flags_q;
  flags_t flags_d;

  spf_overflow #(.DATA_W(DATA_W)) i_ovf (
    .op_class (op_class),
    .op_a     (op_a),
    .op_b     (op_b),
    .ovf      (ovf)
  );

  spf_parity #(.DATA_W(DATA_W)) i_par (
    .data (result),
    .even (par_even)
  );

  assign cnt_nz = |byte_count;

  spf_pv_select i_sel (
    .op_class (op_class),
    .ovf      (ovf),
    .par_even (par_even),
    .cnt_nz   (cnt_nz),
    .int_en   (int_en),
    .upd      (upd),
    .pv_src   (pv_src)
  );

  assign load_en = flag_we & upd;

  always_comb begin
    flags_d = flags_q;
    if (load_en) begin
      flags_d.sign = result[MSB];
      flags_d.pv   = pv_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  spf_cond_eval i_cond (
    .flags     (flags_q),
    .cond_sel  (cond_sel),
    .cond_true (cond_true)
  );

  assign sign_flag = flags_q.sign;
  assign pv_flag   = flags_q.pv;

endmodule

// File: rtl/spf_flag_checker.sv
module spf_flag_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag_we,
  input logic [3:0]        op_class,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] result,
  input logic [CNT_W-1:0]  byte_count,
  input logic              int_en,
  input logic [1:0]        cond_sel,
  input logic              sign_flag,
  input logic              pv_flag,
  input logic              cond_true
);

  localparam int MSB = DATA_W - 1;

  logic a_s, b_s, r_s;
  logic add_ovf_ref, sub_ovf_ref;
  logic upd_class;

  assign a_s = op_a[MSB];
  assign b_s = op_b[MSB];
  assign r_s = result[MSB];
  assign add_ovf_ref = (a_s == b_s) && (r_s != a_s);
  assign sub_ovf_ref = (a_s != b_s) && (r_s != a_s);
  assign upd_class   = (op_class <= 4'd8) && (op_class != 4'd6);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!sign_flag && !pv_flag));

  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ($stable(sign_flag) && $stable(pv_flag)));

  assert_sign_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && upd_class) |=> (sign_flag == $past(r_s)));

  assert_parity_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op_class == 4'd4 || op_class == 4'd5)) |=> (pv_flag == ~(^$past(result))));

  assert_add_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_class == 4'd2) |=> (pv_flag == $past(add_ovf_ref)));

  assert_sub_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_class == 4'd3) |=> (pv_flag == $past(sub_ovf_ref)));

  assert_block_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_class == 4'd7) |=> (pv_flag == ($past(byte_count) != '0)));

  assert_irq_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_class == 4'd8) |=> (pv_flag == $past(int_en)));

  assert_no_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_class) |=> ($stable(sign_flag) && $stable(pv_flag)));

  assert_cond_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 2'd1) |-> (cond_true == sign_flag));

  assert_cond_pv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 2'd2) |-> (cond_true != pv_flag));

endmodule

bind spf_flag_unit spf_flag_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_spf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flag_we    (flag_we),
  .op_class   (op_class),
  .op_a       (op_a),
  .op_b       (op_b),
  .result     (result),
  .byte_count (byte_count),
  .int_en     (int_en),
  .cond_sel   (cond_sel),
  .sign_flag  (sign_flag),
  .pv_flag    (pv_flag),
  .cond_true  (cond_true)
);

// File: tb/test_spf_flag_unit.sv
`timescale 1ns/100ps
module test_spf_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flag_we;
  logic [3:0]  op_class;
  logic [7:0]  op_a, op_b, result;
  logic [15:0] byte_count;
  logic        int_en;
  logic [1:0]  cond_sel;
  logic        sign_flag, pv_flag, cond_true;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  bit  m_sign = 1'b0;
  bit  m_pv = 1'b0;

  always #2.5 clk = ~clk;

  spf_flag_unit i_spf_flag_unit (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .op_class(op_class),
    .op_a(op_a), .op_b(op_b), .result(result), .byte_count(byte_count),
    .int_en(int_en), .cond_sel(cond_sel), .sign_flag(sign_flag),
    .pv_flag(pv_flag), .cond_true(cond_true)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic bit even_ones(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return (c % 2) == 0;
  endfunction

  function automatic bit signed_ovf(input logic [7:0] a, input logic [7:0] b, input bit sub);
    int s;
    s = sub ? (int'($signed(a)) - int'($signed(b))) : (int'($signed(a)) + int'($signed(b)));
    return (s > 127) || (s < -128);
  endfunction

  function automatic string pv_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R6";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5: return "R4";
      4'd7:       return "R7";
      4'd8:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic check_conds();
    for (int s = 0; s < 4; s++) begin
      cond_sel = 2'(s);
      #0.2;
      case (s)
        0: check("R10", "cond positive", cond_true, !m_sign);
        1: check("R10", "cond minus",    cond_true,  m_sign);
        2: check("R10", "cond odd",      cond_true, !m_pv);
        default: check("R10", "cond even", cond_true, m_pv);
      endcase
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] r, input logic [15:0] cnt, input bit ie, input bit we);
    string ts, tp;
    @(negedge clk);
    op_class = op; op_a = a; op_b = b; result = r;
    byte_count = cnt; int_en = ie; flag_we = we;
    @(posedge clk);
    if (!we) begin
      ts = "R2"; tp = "R2";
    end else if (op == 4'd6 || op > 4'd8) begin
      ts = "R9"; tp = "R9";
    end else begin
      ts = "R3"; tp = pv_tag(op);
      m_sign = r[7];
      case (op)
        4'd0: m_pv = (a == 8'h7F);
        4'd1: m_pv = (a == 8'h80);
        4'd2: m_pv = signed_ovf(a, b, 1'b0);
        4'd3: m_pv = signed_ovf(a, b, 1'b1);
        4'd4, 4'd5: m_pv = even_ones(r);
        4'd7: m_pv = (cnt != 16'd0);
        default: m_pv = ie;
      endcase
    end
    #1;
    check(ts, "sign flag", sign_flag, m_sign);
    check(tp, "pv flag",   pv_flag,   m_pv);
    check_conds();
  endtask

  task automatic do_arith(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b, input bit we);
    logic [7:0] r;
    case (op)
      4'd0: r = a + 8'd1;
      4'd1: r = a - 8'd1;
      4'd2: r = a + b;
      default: r = a - b;
    endcase
    apply(op, a, b, r, 16'd5, 1'b0, we);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] op;
    logic [7:0] a, b, r;
    logic [15:0] cnt;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; flag_we = 1'b0; op_class = 4'd4; op_a = 8'h00; op_b = 8'h00;
    result = 8'h00; byte_count = 16'd0; int_en = 1'b0; cond_sel = 2'd0;
    #1;
    check("R1", "sign at reset", sign_flag, 1'b0);
    check("R1", "pv at reset",   pv_flag,   1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R6 increment/decrement boundaries
    do_arith(4'd0, 8'h7F, 8'h00, 1'b1);
    do_arith(4'd0, 8'h7E, 8'h00, 1'b1);
    do_arith(4'd0, 8'hFF, 8'h00, 1'b1);
    do_arith(4'd1, 8'h80, 8'h00, 1'b1);
    do_arith(4'd1, 8'h81, 8'h00, 1'b1);
    do_arith(4'd1, 8'h00, 8'h00, 1'b1);
    // R5 add/subtract overflow
    do_arith(4'd2, 8'h40, 8'h40, 1'b1);
    do_arith(4'd2, 8'hFF, 8'h01, 1'b1);
    do_arith(4'd2, 8'h80, 8'h80, 1'b1);
    do_arith(4'd3, 8'h80, 8'h01, 1'b1);
    do_arith(4'd3, 8'h7F, 8'hFF, 1'b1);
    do_arith(4'd3, 8'h05, 8'h07, 1'b1);
    // R4 parity; sign independent of parity
    apply(4'd4, 8'h00, 8'h00, 8'h00, 16'd0, 1'b0, 1'b1);
    apply(4'd4, 8'h00, 8'h00, 8'hFF, 16'd0, 1'b0, 1'b1);
    apply(4'd5, 8'h00, 8'h00, 8'h07, 16'd0, 1'b0, 1'b1);
    apply(4'd5, 8'h00, 8'h00, 8'h81, 16'd0, 1'b0, 1'b1);
    // R7 block counter
    apply(4'd7, 8'h00, 8'h00, 8'h10, 16'd0, 1'b1, 1'b1);
    apply(4'd7, 8'h00, 8'h00, 8'h90, 16'd1, 1'b0, 1'b1);
    apply(4'd7, 8'h00, 8'h00, 8'h10, 16'h8000, 1'b0, 1'b1);
    // R8 interrupt enable copy
    apply(4'd8, 8'h00, 8'h00, 8'h3C, 16'd0, 1'b1, 1'b1);
    apply(4'd8, 8'h00, 8'h00, 8'hC3, 16'd7, 1'b0, 1'b1);
    // R9 one-byte rotate and reserved codes hold flags
    apply(4'd4, 8'h00, 8'h00, 8'h81, 16'd0, 1'b0, 1'b1);
    apply(4'd6, 8'h00, 8'h00, 8'h01, 16'd0, 1'b0, 1'b1);
    apply(4'd12, 8'h00, 8'h00, 8'h02, 16'd0, 1'b0, 1'b1);
    apply(4'd15, 8'h7F, 8'h7F, 8'h00, 16'd0, 1'b1, 1'b1);
    // R2 write enable low holds flags
    apply(4'd4, 8'h00, 8'h00, 8'h00, 16'd0, 1'b0, 1'b0);
    apply(4'd8, 8'h00, 8'h00, 8'h00, 16'd0, 1'b0, 1'b0);

    // R1 asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    m_sign = 1'b0; m_pv = 1'b0;
    check("R1", "sign after async reset", sign_flag, 1'b0);
    check("R1", "pv after async reset",   pv_flag,   1'b0);
    @(negedge clk); rst_n = 1'b1;

    // Constrained random mix
    for (int k = 0; k < 600; k++) begin
      op = 4'($urandom_range(0, 11));
      a = 8'($urandom); b = 8'($urandom); r = 8'($urandom);
      cnt = (($urandom % 4) == 0) ? 16'd0 : 16'($urandom);
      case (op)
        4'd0: r = a + 8'd1;
        4'd1: r = a - 8'd1;
        4'd2: r = a + b;
        4'd3: r = a - b;
        default: ;
      endcase
      apply(op, a, b, r, cnt, 1'($urandom), (($urandom % 8) != 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule